// File: doc/BRIEF.md
# Stack Memory Pointer Access Unit

This block holds a small local stack memory and serves one access per clock. Each access carries a command field one bit wider than the memory address, plus a bit that chooses between storing and loading. When the top bit of the field is clear, the remaining bits are used as an absolute address. When it is set, the field instead picks one of two stack pointers. It also gives a signed offset or step and an update rule. The rule is either indexed access, which leaves the pointer alone, or a pre-update or post-update of the pointer by the signed step. A negative step gives decrement and a positive step gives increment. A push is therefore a pre-update store with step -1, and a pop is a post-update load with step +1.

Loaded data appears one cycle after the command, together with a valid strobe. Pointer updates take effect in the same clock edge as the access. Both pointers are visible as outputs. Each pointer can also be overwritten through its own load strobe, which shares one load value bus.

Top module: `stk_ptr_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, both pointers read 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: With field bit 8 = 0, the access uses field bits 7:0 as the memory address, and neither pointer changes.
- R3: `cmd_write` = 1 stores `cmd_wdata` at the access address and raises no `rd_valid`. `cmd_write` = 0 loads from the access address.
- R4: A load command issued at edge t gives `rd_valid` = 1 and the stored word on `rd_data` after edge t+1. In any cycle without a load command, `rd_valid` is 0 afterwards and `rd_data` keeps its last value.
- R5: With bit 8 = 1 and update bits 6:5 = 00 (indexed), the address is pointer + sign-extended bits 4:0, and the pointer is unchanged.
- R6: With update bits 6:5 = 01 (pre-update), the pointer becomes pointer + step, and the access uses the new value.
- R7: With update bits 6:5 = 10 (post-update), the access uses the old pointer, and the pointer becomes pointer + step.
- R8: Update code 11 behaves exactly like indexed access (code 00).
- R9: Field bit 7 picks pointer B when 1 and pointer A when 0. The pointer that is not picked never changes because of the access.
- R10: All pointer and address arithmetic wraps modulo 256.
- R11: `ld_a` / `ld_b` load `ld_value` into pointer A / B at the next edge. A load takes priority over a same-cycle update of the same pointer. The access itself still uses the pointer value held before the edge.
- R12: A load of an address written in the directly preceding cycle returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Access command present this cycle |
| cmd_field | input | ADDR_W+1 (9) | Absolute address or pointer-mode descriptor |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_wdata | input | DATA_W (32) | Word to store |
| ld_a | input | 1 | Overwrite pointer A with `ld_value` |
| ld_b | input | 1 | Overwrite pointer B with `ld_value` |
| ld_value | input | ADDR_W (8) | New pointer value for loads |
| rd_data | output | DATA_W (32) | Loaded word, registered |
| rd_valid | output | 1 | `rd_data` carries the result of the previous cycle's load |
| ptr_a | output | ADDR_W (8) | Current pointer A |
| ptr_b | output | ADDR_W (8) | Current pointer B |

## Verification
A pointer register that takes the wrong value shows up on `ptr_a` or `ptr_b` at the very next edge. The reference model compares both pointers on every cycle, so such an error cannot stay hidden behind later accesses. A wrong address computation is quieter. A bad store only shows when that location is loaded, which the push-then-pop sequences and the long mixed run do within a few cycles. A bad load shows one cycle later on `rd_data`. A latency or strobe fault appears as a `rd_valid` mismatch in the cycle directly after the command.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  // Update rule carried in the two bits below the pointer select bit
  typedef enum logic [1:0] {
    UPD_INDEX  = 2'b00,
    UPD_PRE    = 2'b01,
    UPD_POST   = 2'b10,
    UPD_INDEX2 = 2'b11
  } upd_mode_e;

  function automatic logic mode_moves_ptr(upd_mode_e m);
    return (m == UPD_PRE) || (m == UPD_POST);
  endfunction
endpackage

// File: rtl/stk_addr_gen.sv
`timescale 1ns/1ps
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NPTR   = 2
) (
  input  logic                         cmd_valid,
  input  logic [ADDR_W:0]              cmd_field,
  input  logic [NPTR-1:0][ADDR_W-1:0]  ptr_q,
  output logic [ADDR_W-1:0]            acc_addr,
  output logic [NPTR-1:0]              upd_en,
  output logic [ADDR_W-1:0]            upd_val
);
  localparam int OFS_W = ADDR_W - 3;
  localparam int SEL_BIT = ADDR_W - 1;

  logic              ptr_mode;
  logic              sel;
  upd_mode_e         mode;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sum;

  assign ptr_mode = cmd_field[ADDR_W];
  assign sel      = cmd_field[SEL_BIT];
  assign mode     = upd_mode_e'(cmd_field[ADDR_W-2:ADDR_W-3]);
  assign step     = {{(ADDR_W-OFS_W){cmd_field[OFS_W-1]}}, cmd_field[OFS_W-1:0]};
  assign base     = ptr_q[sel];
  assign sum      = base + step;

  always_comb begin
    if (!ptr_mode) begin
      acc_addr = cmd_field[ADDR_W-1:0];
    end else begin
      unique case (mode)
        UPD_PRE:  acc_addr = sum;
        UPD_POST: acc_addr = base;
        default:  acc_addr = sum;
      endcase
    end
  end

  assign upd_val = sum;

  for (genvar g = 0; g < NPTR; g++) begin : g_upd
    assign upd_en[g] = cmd_valid && ptr_mode && mode_moves_ptr(mode) && (sel == g[0]);
  end
endmodule

// File: rtl/stk_ptr_file.sv
`timescale 1ns/1ps
module stk_ptr_file #(
  parameter int ADDR_W = 8,
  parameter int NPTR   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPTR-1:0]              upd_en,
  input  logic [ADDR_W-1:0]            upd_val,
  input  logic [NPTR-1:0]              ld_en,
  input  logic [ADDR_W-1:0]            ld_val,
  output logic [NPTR-1:0][ADDR_W-1:0]  ptr_q
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= '0;
      end else if (ld_en[g]) begin
        ptr_q[g] <= ld_val;
      end else if (upd_en[g]) begin
        ptr_q[g] <= upd_val;
      end
    end
  end
endmodule

// File: rtl/stk_mem.sv
`timescale 1ns/1ps
module stk_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
    end
  end
endmodule

// File: rtl/stk_ptr_unit.sv
`timescale 1ns/1ps
module stk_ptr_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W:0]   cmd_field,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic [ADDR_W-1:0] ld_value,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] ptr_a,
  output logic [ADDR_W-1:0] ptr_b
);
  localparam int NPTR = 2;

  logic [NPTR-1:0][ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0]           acc_addr;
  logic [NPTR-1:0]             upd_en;
  logic [ADDR_W-1:0]           upd_val;
  logic [NPTR-1:0]             ld_en;

  assign ld_en = {ld_b, ld_a};

  stk_addr_gen #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_agen (
    .cmd_valid (cmd_valid),
    .cmd_field (cmd_field),
    .ptr_q     (ptr_q),
    .acc_addr  (acc_addr),
    .upd_en    (upd_en),
    .upd_val   (upd_val)
  );

  stk_ptr_file #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_val (upd_val),
    .ld_en   (ld_en),
    .ld_val  (ld_value),
    .ptr_q   (ptr_q)
  );

  stk_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .we     (cmd_valid && cmd_write),
    .re     (cmd_valid && !cmd_write),
    .addr   (acc_addr),
    .wdata  (cmd_wdata),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  assign ptr_a = ptr_q[0];
  assign ptr_b = ptr_q[1];
endmodule

// File: rtl/stk_ptr_unit_chk.sv
`timescale 1ns/1ps
module stk_ptr_unit_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [ADDR_W:0]   cmd_field,
  input logic              cmd_write,
  input logic              ld_a,
  input logic              ld_b,
  input logic [ADDR_W-1:0] ld_value,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] ptr_a,
  input logic [ADDR_W-1:0] ptr_b
);
  localparam int OFS_W = ADDR_W - 3;

  logic [ADDR_W-1:0] step_ext;
  logic [1:0]        mode;
  logic              pmode;
  logic              is_load;

  assign step_ext = {{(ADDR_W-OFS_W){cmd_field[OFS_W-1]}}, cmd_field[OFS_W-1:0]};
  assign mode     = cmd_field[ADDR_W-2:ADDR_W-3];
  assign pmode    = cmd_field[ADDR_W];
  assign is_load  = cmd_valid && !cmd_write;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ptr_a == '0 && ptr_b == '0 && !rd_valid)); // R1

  AST_DIRECT_KEEPS_PTRS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !pmode && !ld_a && !ld_b) |=> ($stable(ptr_a) && $stable(ptr_b))); // R2

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (rst)
    is_load |=> rd_valid); // R4

  AST_NO_LOAD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !is_load |=> !rd_valid); // R4

  AST_INDEX_KEEPS_PTRS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pmode && (mode == 2'b00 || mode == 2'b11) && !ld_a && !ld_b)
      |=> ($stable(ptr_a) && $stable(ptr_b))); // R5

  AST_POST_STEP_A: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pmode && !cmd_field[ADDR_W-1] && mode == 2'b10 && !ld_a)
      |=> (ptr_a == $past(ptr_a + step_ext))); // R7

  AST_UNPICKED_B_STILL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pmode && !cmd_field[ADDR_W-1] && !ld_b) |=> $stable(ptr_b)); // R9

  AST_LOAD_A_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_a |=> (ptr_a == $past(ld_value))); // R11

  AST_LOAD_B_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_b |=> (ptr_b == $past(ld_value))); // R11
endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_field (cmd_field),
  .cmd_write (cmd_write),
  .ld_a      (ld_a),
  .ld_b      (ld_b),
  .ld_value  (ld_value),
  .rd_valid  (rd_valid),
  .ptr_a     (ptr_a),
  .ptr_b     (ptr_b)
);

// File: tb/test_stk_ptr_unit.sv
`timescale 1ns/1ps
module test_stk_ptr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd_field = '0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        ld_a = 1'b0;
  logic        ld_b = 1'b0;
  logic [7:0]  ld_value = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [7:0]  ptr_a;
  logic [7:0]  ptr_b;

  always #2.5 clk = ~clk;

  stk_ptr_unit i_stk_ptr_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_field(cmd_field),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .ld_a(ld_a), .ld_b(ld_b),
    .ld_value(ld_value), .rd_data(rd_data), .rd_valid(rd_valid),
    .ptr_a(ptr_a), .ptr_b(ptr_b)
  );

  // reference state
  logic [31:0] m_mem [256];
  int          m_pa, m_pb;
  bit          m_rdv;
  logic [31:0] m_rdd;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 0;
  int unsigned rng = 32'h1234_5678;

  function automatic logic [8:0] pf(bit sel, logic [1:0] mode, logic [4:0] ofs);
    return {1'b1, sel, mode, ofs};
  endfunction

  function automatic logic [8:0] df(int a);
    return {1'b0, a[7:0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(bit v, logic [8:0] f, bit w, logic [31:0] d, bit la, bit lb, logic [7:0] lv);
    int sv, base, addr, np;
    bit upd;
    upd = 0; np = 0;
    sv = f[4] ? int'(f[4:0]) - 32 : int'(f[4:0]);
    if (!f[8]) begin
      addr = int'(f[7:0]);
    end else begin
      base = f[7] ? m_pb : m_pa;
      case (f[6:5])
        2'b01: begin np = (base + sv) & 255; addr = np; upd = 1; end
        2'b10: begin addr = base; np = (base + sv) & 255; upd = 1; end
        default: addr = (base + sv) & 255;
      endcase
    end
    m_rdv = 0;
    if (v) begin
      if (w) m_mem[addr] = d;
      else begin
        m_rdd = m_mem[addr];
        m_rdv = 1;
      end
      if (upd) begin
        if (f[7]) m_pb = np; else m_pa = np;
      end
    end
    if (la) m_pa = int'(lv);
    if (lb) m_pb = int'(lv);
  endtask

  task automatic cyc(bit v, logic [8:0] f, bit w, logic [31:0] d,
                     bit la, bit lb, logic [7:0] lv, string req);
    cmd_valid = v; cmd_field = f; cmd_write = w; cmd_wdata = d;
    ld_a = la; ld_b = lb; ld_value = lv;
    model(v, f, w, d, la, lb, lv);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    chk(req, "ptr_a", {24'd0, ptr_a}, m_pa[31:0]);
    chk(req, "ptr_b", {24'd0, ptr_b}, m_pb[31:0]);
    chk(req, "rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv});
    chk(req, "rd_data", rd_data, m_rdd);
  endtask

  task automatic acc(logic [8:0] f, bit w, logic [31:0] d, string req);
    cyc(1, f, w, d, 0, 0, 8'd0, req);
  endtask

  task automatic ldp(bit which_b, logic [7:0] v, string req);
    cyc(0, 9'd0, 0, 32'd0, !which_b, which_b, v, req);
  endtask

  function automatic int unsigned nxt(int unsigned s);
    int unsigned x;
    x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_pa = 0; m_pb = 0; m_rdv = 0; m_rdd = '0;
    repeat (3) @(negedge clk);
    n_vec++;
    chk("R1", "ptr_a in reset", {24'd0, ptr_a}, 32'd0);
    chk("R1", "ptr_b in reset", {24'd0, ptr_b}, 32'd0);
    chk("R1", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    chk("R1", "rd_data in reset", rd_data, 32'd0);
    rst = 1'b0;
    cyc(0, 9'd0, 0, 32'd0, 0, 0, 8'd0, "R1");

    // R2 R3: fill every location by absolute address
    for (int i = 0; i < 256; i++)
      acc(df(i), 1, 32'hA500_0000 ^ (i * 32'h0101_0101), "R2");
    // R3 R4: absolute loads, then idle keeps data
    acc(df(0), 0, 32'd0, "R3");
    acc(df(255), 0, 32'd0, "R3");
    acc(df(8'h85), 0, 32'd0, "R4");
    cyc(0, 9'd0, 0, 32'd0, 0, 0, 8'd0, "R4");
    acc(df(8'h85), 1, 32'hDEAD_0085, "R3");
    cyc(0, 9'd0, 0, 32'd0, 0, 0, 8'd0, "R4");
    // R11: pointer loads
    ldp(0, 8'h80, "R11");
    ldp(1, 8'h40, "R11");
    // R6: push onto B (pre-update step -1)
    for (int i = 0; i < 4; i++)
      acc(pf(1, 2'b01, 5'h1F), 1, 32'hC0DE_0000 + i, "R6");
    // R7: pop from B (post-update step +1), reverse order
    for (int i = 0; i < 4; i++)
      acc(pf(1, 2'b10, 5'h01), 0, 32'd0, "R7");
    // R5: indexed around A
    acc(pf(0, 2'b00, 5'd2), 0, 32'd0, "R5");
    acc(pf(0, 2'b00, 5'h1D), 0, 32'd0, "R5");
    acc(pf(0, 2'b00, 5'd7), 1, 32'h1234_0007, "R5");
    acc(df(8'h87), 0, 32'd0, "R5");
    // R8: code 11 matches indexed
    acc(pf(0, 2'b11, 5'd7), 0, 32'd0, "R8");
    acc(pf(1, 2'b11, 5'h10), 0, 32'd0, "R8");
    // R9: pre-update on A leaves B, and the reverse
    acc(pf(0, 2'b01, 5'd3), 1, 32'h0000_AAAA, "R9");
    acc(pf(1, 2'b10, 5'h1C), 0, 32'd0, "R9");
    // R10: wrap below zero and above 255
    ldp(0, 8'h02, "R10");
    acc(pf(0, 2'b01, 5'h10), 1, 32'hBEEF_00F2, "R10");
    acc(df(8'hF2), 0, 32'd0, "R10");
    ldp(1, 8'hFE, "R10");
    acc(pf(1, 2'b10, 5'd4), 0, 32'd0, "R10");
    acc(pf(1, 2'b00, 5'h1F), 0, 32'd0, "R10");
    // R11: load beats a same-cycle update, access uses old pointer
    cyc(1, pf(0, 2'b01, 5'd1), 1, 32'h5A5A_0001, 1, 0, 8'h33, "R11");
    acc(df(8'hF3), 0, 32'd0, "R11");
    cyc(1, pf(1, 2'b10, 5'd1), 0, 32'd0, 0, 1, 8'h10, "R11");
    // R12: write then immediate read of the same address
    acc(df(8'h10), 1, 32'h0F0F_1010, "R12");
    acc(df(8'h10), 0, 32'd0, "R12");
    acc(pf(1, 2'b00, 5'd0), 1, 32'h7777_0010, "R12");
    acc(pf(1, 2'b10, 5'd0), 0, 32'd0, "R12");
    // R9 R10 R6 R7: long mixed run
    for (int i = 0; i < 3000; i++) begin
      bit v, w, la, lb;
      logic [8:0] f;
      rng = nxt(rng);
      v  = rng[0] | rng[1];
      w  = rng[2];
      la = (rng[7:3] == 5'd0);
      lb = (rng[12:8] == 5'd1);
      f  = rng[21:13];
      rng = nxt(rng);
      cyc(v, f, w, rng, la, lb, rng[15:8], "R9");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule